// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic and logic stage of a 16-bit word-oriented processor. Operand fetch and addressing happen elsewhere. The block receives a source and a destination operand, an operation code and a byte/word select. In the same cycle it returns the data result and the candidate next value of the 16-bit status word. When the sequencer raises the flag write enable, the status register takes that candidate value on the next rising clock edge.

Each operation has its own set of flags it may change. All other status bits pass through unchanged, so flags from earlier instructions survive operations that do not own them.

In byte mode the operation works on the upper byte of each operand, and the lower byte of the destination passes through untouched.

Status bits are numbered most-significant-first: status bit 0 is vector index 15. The flag layout is:

| Flag | Status bit | Vector index |
|---|---|---|
| logical-greater (L) | 0 | 15 |
| arithmetic-greater (A) | 1 | 14 |
| equal (E) | 2 | 13 |
| carry (C) | 3 | 12 |
| overflow (V) | 4 | 11 |
| odd parity (P) | 5 | 10 |

Status bit 6 and the four-bit field in bits 12-15 are never written by this block. They keep their value.

Top module: `alu16_status_unit`

## Requirements
- R1: The status register `st_q` resets to 0x0000 under active-low `rst_n`. Flags sit at the vector indices given in the table above. No operation writes any other status index.
- R2: On a rising edge with `flag_we`=1, `st_q` takes the value `st_next` showed before the edge. With `flag_we`=0, `st_q` holds its value.
- R3: The six arithmetic operations compute `result` and update L, A, E, C and V:
  - add (code 0): dst+src.
  - subtract (code 1): dst−src.
  - negate (code 8): −dst.
  - absolute value (code 9): |dst|.
  - increment (code 10): dst+1.
  - decrement (code 11): dst−1.

  C is the carry out of the operand width; on subtraction it means no borrow. For add, V is set when both addends share a sign and the result's sign differs from it. For subtract, V is set when the operands differ in sign and the result's sign differs from the destination's. Negating the most negative value sets V. Absolute value always clears C.
- R4: For every operation with codes 0, 1 and 3-12, the comparison flags come from the result compared with zero:
  - L = result nonzero.
  - A = result positive and nonzero in two's complement.
  - E = result zero.
- R5: Compare (code 2) sets the comparison flags from source against destination: L for unsigned source > destination, A for signed source > destination, E for equality. It changes no other flag in word mode, and `result` equals `dst_opd`.
- R6: The logic operations update only L, A and E; C, V and P keep their values:
  - AND (code 3): dst&src.
  - set-ones (code 4): dst|src.
  - set-zeros (code 5): dst&~src.
  - XOR (code 6): dst^src.
  - invert (code 7): ~dst.
  - move (code 12): result = src.
- R7: Compare-ones (code 15) sets E when every one bit of the source is also one in the destination. Compare-zeros (code 16) sets E when source and destination share no one bit. Both change no other flag, and `result` equals `dst_opd`.
- R8: Clear (code 13) produces all zeros and set-ones-word (code 14) produces all ones. Neither changes any flag.
- R9: With `byte_mode`=1, operands are the upper bytes and `result[7:0]` equals `dst_opd[7:0]`. Carry, overflow and sign are taken at the byte's bit 7.
- R10: In byte mode, add, subtract and move also update P, set when the result byte holds an odd number of ones. Byte compare sets P from the source byte. In word mode P never changes.
- R11: Codes 17 to 31 return `dst_opd` unchanged and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the status register |
| op_sel | input | 5 | Operation code |
| byte_mode | input | 1 | 1 = operate on upper bytes, 0 = full word |
| flag_we | input | 1 | Load `st_next` into `st_q` at the next edge |
| src_opd | input | 16 | Source operand |
| dst_opd | input | 16 | Destination operand |
| result | output | 16 | Data result (combinational) |
| st_next | output | 16 | Candidate status word (combinational) |
| st_q | output | 16 | Registered status word |

## Verification
`result` and `st_next` are purely combinational: they are due in the same cycle the operands and code are applied. `st_q` is due one rising edge after a cycle with `flag_we` high.

The bench drives inputs on the falling edge and compares `result` and `st_next` 1 ns later. It then compares `st_q` 1 ns after the following rising edge against a model status word, which it advances only when it applied `flag_we`. Because the model status word carries flags forward from earlier vectors, the checks of untouched flags run against values that are genuinely nonzero.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int ST_W = 16;
  localparam int OP_W = 5;

  // Flag positions, numbered most-significant-first.
  localparam int FB_LGT = 0;
  localparam int FB_AGT = 1;
  localparam int FB_EQ  = 2;
  localparam int FB_CY  = 3;
  localparam int FB_OV  = 4;
  localparam int FB_PAR = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_CMP  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_ANDN = 5'd5,
    OP_XOR  = 5'd6,
    OP_INV  = 5'd7,
    OP_NEG  = 5'd8,
    OP_ABS  = 5'd9,
    OP_INC  = 5'd10,
    OP_DEC  = 5'd11,
    OP_MOV  = 5'd12,
    OP_CLR  = 5'd13,
    OP_SETO = 5'd14,
    OP_COC  = 5'd15,
    OP_CZC  = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic lgt;
    logic agt;
    logic eq;
    logic cy;
    logic ov;
    logic par;
  } flag_set_t;

  // Vector index of a status bit given in most-significant-first numbering.
  function automatic int st_pos(input int msb_first);
    return ST_W - 1 - msb_first;
  endfunction

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG) ||
           (op == OP_ABS) || (op == OP_INC) || (op == OP_DEC);
  endfunction

  function automatic logic is_logic(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ANDN) ||
           (op == OP_XOR) || (op == OP_INV) || (op == OP_MOV);
  endfunction

  // Which flags an operation is allowed to alter.
  function automatic flag_set_t op_mask(input alu_op_e op, input logic byte_m);
    flag_set_t m;
    m = '0;
    if (is_arith(op)) begin
      m.lgt = 1'b1; m.agt = 1'b1; m.eq = 1'b1; m.cy = 1'b1; m.ov = 1'b1;
      m.par = byte_m && ((op == OP_ADD) || (op == OP_SUB));
    end else if (is_logic(op)) begin
      m.lgt = 1'b1; m.agt = 1'b1; m.eq = 1'b1;
      m.par = byte_m && (op == OP_MOV);
    end else if (op == OP_CMP) begin
      m.lgt = 1'b1; m.agt = 1'b1; m.eq = 1'b1;
      m.par = byte_m;
    end else if ((op == OP_COC) || (op == OP_CZC)) begin
      m.eq = 1'b1;
    end
    return m;
  endfunction

  // Spread a flag set onto the status word.
  function automatic logic [ST_W-1:0] to_st(input flag_set_t f);
    logic [ST_W-1:0] v;
    v = '0;
    v[st_pos(FB_LGT)] = f.lgt;
    v[st_pos(FB_AGT)] = f.agt;
    v[st_pos(FB_EQ)]  = f.eq;
    v[st_pos(FB_CY)]  = f.cy;
    v[st_pos(FB_OV)]  = f.ov;
    v[st_pos(FB_PAR)] = f.par;
    return v;
  endfunction

endpackage

// File: rtl/alu16_align.sv
// Places the active lane of each operand at the top of the word.
// In byte mode the lower half is forced to zero, so carry, sign and
// overflow of a full-width adder fall exactly on the byte boundary.
module alu16_align #(
  parameter int DATA_W = 16
) (
  input  logic              byte_m,
  input  logic [DATA_W-1:0] src_in,
  input  logic [DATA_W-1:0] dst_in,
  output logic [DATA_W-1:0] a_al,
  output logic [DATA_W-1:0] b_al,
  output logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] unit
);
  localparam int HALF = DATA_W / 2;

  localparam logic [DATA_W-1:0] WORD_MASK = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] BYTE_MASK = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [DATA_W-1:0] WORD_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] BYTE_ONE  = DATA_W'(1) << HALF;

  assign lane_mask = byte_m ? BYTE_MASK : WORD_MASK;
  assign unit      = byte_m ? BYTE_ONE  : WORD_ONE;
  assign a_al      = src_in & lane_mask;
  assign b_al      = dst_in & lane_mask;
endmodule

// File: rtl/alu16_datapath.sv
// One shared adder serves all arithmetic codes; the logic codes use a
// separate mux. The output is already clipped to the active lane.
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a_al,
  input  logic [DATA_W-1:0] b_al,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] unit,
  output logic [DATA_W-1:0] res_al,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] f_sum(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y,
                                            input logic              ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  function automatic logic f_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [DATA_W-1:0] x_in, y_in, y_eff, sum, pre_res;
  logic              inv_y, c_in, c_out;

  always_comb begin
    x_in  = '0;
    y_in  = '0;
    inv_y = 1'b0;
    c_in  = 1'b0;
    case (op)
      OP_ADD: begin x_in = b_al; y_in = a_al; end
      OP_SUB: begin x_in = b_al; y_in = a_al; inv_y = 1'b1; c_in = 1'b1; end
      OP_NEG: begin y_in = b_al; inv_y = 1'b1; c_in = 1'b1; end
      OP_ABS: begin
        if (b_al[MSB]) begin
          y_in = b_al; inv_y = 1'b1; c_in = 1'b1;
        end else begin
          x_in = b_al;
        end
      end
      OP_INC: begin x_in = b_al; y_in = unit; end
      OP_DEC: begin x_in = b_al; y_in = unit; inv_y = 1'b1; c_in = 1'b1; end
      default: ;
    endcase
  end

  assign y_eff          = inv_y ? ~y_in : y_in;
  assign {c_out, sum}   = f_sum(x_in, y_eff, c_in);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_NEG,
      OP_ABS, OP_INC, OP_DEC: pre_res = sum;
      OP_AND:  pre_res = b_al & a_al;
      OP_OR:   pre_res = b_al | a_al;
      OP_ANDN: pre_res = b_al & ~a_al;
      OP_XOR:  pre_res = b_al ^ a_al;
      OP_INV:  pre_res = ~b_al;
      OP_MOV:  pre_res = a_al;
      OP_CLR:  pre_res = '0;
      OP_SETO: pre_res = '1;
      default: pre_res = b_al;
    endcase
  end

  assign res_al = pre_res & lane_mask;
  assign carry  = c_out;
  assign ovf    = f_ovf(x_in[MSB], y_eff[MSB], sum[MSB]);
endmodule

// File: rtl/alu16_flags.sv
// Evaluates every flag, then merges the owned ones into the status word.
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic              byte_m,
  input  logic [DATA_W-1:0] a_al,
  input  logic [DATA_W-1:0] b_al,
  input  logic [DATA_W-1:0] res_al,
  input  logic              carry,
  input  logic              ovf,
  input  logic [ST_W-1:0]   st_cur,
  output logic [ST_W-1:0]   upd_mask,
  output logic [ST_W-1:0]   st_nxt
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  flag_set_t         fv;
  flag_set_t         fm;
  logic              is_cmp;
  logic              res_zero;
  logic [HALF-1:0]   par_src;

  assign is_cmp   = (op == OP_CMP);
  assign res_zero = (res_al == '0);
  assign par_src  = is_cmp ? a_al[MSB -: HALF] : res_al[MSB -: HALF];

  always_comb begin
    fv     = '0;
    fv.cy  = carry;
    fv.ov  = ovf;
    fv.par = ^par_src;
    if (is_cmp) begin
      fv.lgt = a_al > b_al;
      fv.agt = $signed(a_al) > $signed(b_al);
      fv.eq  = a_al == b_al;
    end else begin
      fv.lgt = !res_zero;
      fv.agt = !res_zero && !res_al[MSB];
      fv.eq  = res_zero;
      if (op == OP_COC) fv.eq = (a_al & ~b_al) == '0;
      if (op == OP_CZC) fv.eq = (a_al & b_al) == '0;
    end
  end

  assign fm       = op_mask(op, byte_m);
  assign upd_mask = to_st(fm);
  assign st_nxt   = (st_cur & ~upd_mask) | (to_st(fv) & upd_mask);
endmodule

// File: rtl/alu16_status_unit.sv
module alu16_status_unit
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              byte_mode,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] src_opd,
  input  logic [DATA_W-1:0] dst_opd,
  output logic [DATA_W-1:0] result,
  output logic [ST_W-1:0]   st_next,
  output logic [ST_W-1:0]   st_q
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] a_al, b_al, lane_mask, unit, res_al;
  logic              dp_carry, dp_ovf;
  logic [ST_W-1:0]   upd_mask;

  assign op = alu_op_e'(op_sel);

  alu16_align #(.DATA_W(DATA_W)) align_i (
    .byte_m    (byte_mode),
    .src_in    (src_opd),
    .dst_in    (dst_opd),
    .a_al      (a_al),
    .b_al      (b_al),
    .lane_mask (lane_mask),
    .unit      (unit)
  );

  alu16_datapath #(.DATA_W(DATA_W)) dp_i (
    .op        (op),
    .a_al      (a_al),
    .b_al      (b_al),
    .lane_mask (lane_mask),
    .unit      (unit),
    .res_al    (res_al),
    .carry     (dp_carry),
    .ovf       (dp_ovf)
  );

  alu16_flags #(.DATA_W(DATA_W)) flg_i (
    .op       (op),
    .byte_m   (byte_mode),
    .a_al     (a_al),
    .b_al     (b_al),
    .res_al   (res_al),
    .carry    (dp_carry),
    .ovf      (dp_ovf),
    .st_cur   (st_q),
    .upd_mask (upd_mask),
    .st_nxt   (st_next)
  );

  // Byte mode: the lower half of the destination is carried through.
  assign result = byte_mode ? {res_al[MSB -: HALF], dst_opd[HALF-1:0]} : res_al;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (flag_we) st_q <= st_next;
  end
endmodule

// File: rtl/alu16_status_chk.sv
module alu16_status_chk
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_sel,
  input logic              byte_mode,
  input logic              flag_we,
  input logic [DATA_W-1:0] dst_opd,
  input logic [DATA_W-1:0] result,
  input logic [ST_W-1:0]   st_next,
  input logic [ST_W-1:0]   st_q,
  input logic [ST_W-1:0]   upd_mask
);
  localparam int HALF = DATA_W / 2;
  localparam int I_LGT = ST_W - 1 - FB_LGT;
  localparam int I_EQ  = ST_W - 1 - FB_EQ;
  localparam int I_CY  = ST_W - 1 - FB_CY;
  localparam int I_OV  = ST_W - 1 - FB_OV;
  localparam int I_PAR = ST_W - 1 - FB_PAR;
  localparam logic [ST_W-1:0] EQ_ONLY = ST_W'(1) << I_EQ;

  logic logic_op;
  assign logic_op = (op_sel >= OP_AND && op_sel <= OP_INV) || (op_sel == OP_MOV);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> st_q == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(st_q));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> st_q == $past(st_next));

  p_eq_excl_lgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= OP_MOV && st_next[I_EQ]) |-> !st_next[I_LGT]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    logic_op |-> (st_next[I_OV] == st_q[I_OV]) && (st_next[I_CY] == st_q[I_CY]));

  p_eq_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_COC || op_sel == OP_CZC) |-> ((st_next ^ st_q) & ~EQ_ONLY) == '0);

  p_no_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CLR || op_sel == OP_SETO) |-> (upd_mask == '0) && (st_next == st_q));

  p_low_byte_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[HALF-1:0] == dst_opd[HALF-1:0]);

  p_word_parity_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode |-> st_next[I_PAR] == st_q[I_PAR]);

  p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_CZC) |-> (result == dst_opd) && (st_next == st_q));
endmodule

bind alu16_status_unit alu16_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .byte_mode (byte_mode),
  .flag_we   (flag_we),
  .dst_opd   (dst_opd),
  .result    (result),
  .st_next   (st_next),
  .st_q      (st_q),
  .upd_mask  (upd_mask)
);

// File: tb/alu16_status_unit_tb_top.sv
`timescale 1ns/1ps
module alu16_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op_sel;
  logic        byte_mode;
  logic        flag_we;
  logic [15:0] src_opd, dst_opd;
  logic [15:0] result, st_next, st_q;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_st = 16'h0000;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alu16_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .byte_mode(byte_mode),
    .flag_we(flag_we), .src_opd(src_opd), .dst_opd(dst_opd),
    .result(result), .st_next(st_next), .st_q(st_q)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op);
    if (op <= 5'd1 || (op >= 5'd8 && op <= 5'd11)) return "R3";
    if (op == 5'd2) return "R5";
    if ((op >= 5'd3 && op <= 5'd7) || op == 5'd12) return "R6";
    if (op == 5'd13 || op == 5'd14) return "R8";
    if (op == 5'd15 || op == 5'd16) return "R7";
    return "R11";
  endfunction

  // Reference model written from the requirements in plain integer math.
  function automatic void ref_model(input logic [4:0] op, input logic bm,
                                    input logic [15:0] s, input logic [15:0] d,
                                    input logic [15:0] st,
                                    output logic [15:0] r_o, output logic [15:0] st_o);
    int w, m, h, a, b, r, sa, sb;
    bit l, ag, e, c, v, p, u5, u3, ue, up, zcmp;
    logic [15:0] rv, av;
    w = bm ? 8 : 16;
    m = (1 << w) - 1;
    h = 1 << (w - 1);
    a = bm ? int'(s[15:8]) : int'(s);
    b = bm ? int'(d[15:8]) : int'(d);
    sa = (a >= h) ? a - (1 << w) : a;
    sb = (b >= h) ? b - (1 << w) : b;
    r = b; l = 0; ag = 0; e = 0; c = 0; v = 0; p = 0;
    u5 = 0; u3 = 0; ue = 0; up = 0; zcmp = 0;
    case (op)
      5'd0:  begin r = (b + a) & m; c = (b + a) > m;
                   v = ((a >= h) == (b >= h)) && ((r >= h) != (b >= h)); u5 = 1; up = bm; end
      5'd1:  begin r = (b - a) & m; c = b >= a;
                   v = ((a >= h) != (b >= h)) && ((r >= h) != (b >= h)); u5 = 1; up = bm; end
      5'd8:  begin r = (0 - b) & m; c = (b == 0); v = (b == h); u5 = 1; end
      5'd9:  begin
               if (b >= h) begin r = (0 - b) & m; v = (b == h); end
               else r = b;
               c = 0; u5 = 1;
             end
      5'd10: begin r = (b + 1) & m; c = (b == m); v = (b == h - 1); u5 = 1; end
      5'd11: begin r = (b - 1) & m; c = (b != 0); v = (b == h); u5 = 1; end
      5'd2:  begin l = a > b; ag = sa > sb; e = a == b; u3 = 1; up = bm; end
      5'd3:  begin r = b & a; u3 = 1; end
      5'd4:  begin r = b | a; u3 = 1; end
      5'd5:  begin r = b & ~a & m; u3 = 1; end
      5'd6:  begin r = b ^ a; u3 = 1; end
      5'd7:  begin r = ~b & m; u3 = 1; end
      5'd12: begin r = a; u3 = 1; up = bm; end
      5'd13: r = 0;
      5'd14: r = m;
      5'd15: begin e = (a & ~b & m) == 0; ue = 1; end
      5'd16: begin e = (a & b) == 0; ue = 1; end
      default: ;
    endcase
    rv = r[15:0];
    av = a[15:0];
    if (u5 || (u3 && op != 5'd2)) zcmp = 1;
    if (zcmp) begin l = (r != 0); ag = (r != 0) && (r < h); e = (r == 0); end
    p = (op == 5'd2) ? ^av[7:0] : ^rv[7:0];
    r_o = bm ? {rv[7:0], d[7:0]} : rv;
    st_o = st;
    if (u5 || u3) begin st_o[15] = l; st_o[14] = ag; st_o[13] = e; end
    if (ue) st_o[13] = e;
    if (u5) begin st_o[12] = c; st_o[11] = v; end
    if (up) st_o[10] = p;
  endfunction

  task automatic apply(input logic [4:0] op, input logic bm, input logic [15:0] s,
                       input logic [15:0] d, input logic we);
    logic [15:0] er, en;
    string t;
    @(negedge clk);
    op_sel = op; byte_mode = bm; src_opd = s; dst_opd = d; flag_we = we;
    ref_model(op, bm, s, d, exp_st, er, en);
    t = tag_of(op);
    #1;
    check({t, " result"}, result, er);
    check({t, " st_next"}, st_next, en);
    if (op <= 5'd12 && op != 5'd2) check("R4 cmp-to-zero", {13'd0, st_next[15:13]}, {13'd0, en[15:13]});
    if (bm) check("R9 low byte", {8'd0, result[7:0]}, {8'd0, d[7:0]});
    if (bm && (op <= 5'd2 || op == 5'd12)) check("R10 parity", {15'd0, st_next[10]}, {15'd0, en[10]});
    @(posedge clk);
    #1;
    if (we) exp_st = en;
    check("R2 st_q", st_q, exp_st);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return {(($urandom % 2) != 0) ? 8'h80 : 8'h7F, 8'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; op_sel = '0; byte_mode = 1'b0; flag_we = 1'b0;
    src_opd = '0; dst_opd = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", st_q, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: 7FFF+1 -> 8000 sets L and V only: indices 15 and 11.
    apply(5'd0, 1'b0, 16'h0001, 16'h7FFF, 1'b1);
    check("R1 bit positions", st_q, 16'h8800);
    apply(5'd1, 1'b0, 16'h0001, 16'h0000, 1'b1);   // R3 borrow
    apply(5'd8, 1'b0, 16'h0000, 16'h8000, 1'b1);   // R3 negate min
    apply(5'd9, 1'b0, 16'h0000, 16'h8000, 1'b1);   // R3 abs min
    apply(5'd11, 1'b0, 16'h0000, 16'h0000, 1'b1);  // R3 decrement zero
    apply(5'd10, 1'b0, 16'h0000, 16'hFFFF, 1'b1);  // R3 increment wrap
    apply(5'd0, 1'b1, 16'h8012, 16'h80AB, 1'b1);   // R9 byte carry
    apply(5'd1, 1'b1, 16'h0133, 16'h7F55, 1'b1);   // R10 byte parity
    apply(5'd2, 1'b1, 16'h80FF, 16'h0100, 1'b1);   // R5 signed vs unsigned
    apply(5'd2, 1'b0, 16'h1234, 16'h1234, 1'b1);   // R5 equal
    apply(5'd15, 1'b0, 16'h0F00, 16'hFF00, 1'b1);  // R7 ones covered
    apply(5'd16, 1'b0, 16'h00F0, 16'h0F0F, 1'b1);  // R7 disjoint
    apply(5'd3, 1'b0, 16'hFF00, 16'h00FF, 1'b1);   // R6 keeps C/V
    apply(5'd13, 1'b0, 16'h1111, 16'h2222, 1'b1);  // R8 clear
    apply(5'd14, 1'b1, 16'h1111, 16'h2222, 1'b1);  // R8 set-ones byte
    apply(5'd20, 1'b0, 16'hAAAA, 16'h5555, 1'b1);  // R11 unused code
    apply(5'd4, 1'b0, 16'h0001, 16'h0002, 1'b0);   // R2 hold

    for (int i = 0; i < 800; i++) begin
      apply(5'($urandom % 20), 1'($urandom % 2), pick(), pick(), 1'(($urandom % 4) != 0));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule